// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block runs a short program against a raw NAND flash device. The program is a 32-bit word of eight 4-bit opcodes. Each opcode names one bus phase: a command byte, a column, row or user address, a transfer between the flash and a local byte buffer, a 1- or 2-byte transfer through a data register, or a wait on the ready/busy line followed by a command or a read. Software loads the command bytes, the block and page address, the byte count and the mode fields. It then pulses `start` and waits for `done`.

The controller is a five-state machine. From S_IDLE, a `start` pulse latches the program and moves to S_DECODE. S_DECODE looks at the current slot. An end-of-program opcode, or running past the last slot, leads to S_FINISH. A wait opcode leads to S_WAIT. A buffer phase with a zero count skips the slot and stays in S_DECODE. Any other opcode leads to S_XFER. In S_WAIT, a ready device leads to S_XFER (or back to S_DECODE for an empty buffer phase), and an expired wait counter leads to S_FINISH with the timeout flag set. S_XFER runs one two-cycle strobe per byte (low phase, high phase). After the last byte of the phase it returns to S_DECODE on the next slot. S_FINISH raises `done` for one cycle and returns to S_IDLE.

Top module: `nand_seq_top`

## Requirements
- R1: Slots execute one at a time, starting with instr[31:28] and moving toward instr[3:0].
- R2: Opcode 0x0 ends the program, and at most eight slots execute. When the program ends, `done` is high for exactly one cycle and `busy` falls after it.
- R3: Opcodes 0x4..0x7 issue one byte with `nand_cle` high and `nand_ale` low. The byte is cmd_bytes[31:24], [23:16], [15:8] or [7:0] respectively.
- R4: Opcode 0x1 issues the column with `nand_ale` high. In small-page mode (`large_page`=0) this is one cycle of pg_addr[7:0]. In large-page mode it is two cycles: pg_addr[7:0], then {4'b0, pg_addr[11:8]}.
- R5: Opcode 0x2 issues addr_len+1 row cycles with `nand_ale` high, least significant byte first. The row is {blk_addr, pg_addr[14:10]} in small-page mode and {blk_addr, pg_addr[17:12]} in large-page mode.
- R6: Opcode 0x3 issues one address cycle carrying `user_addr`.
- R7: Opcode 0x8 sends `byte_cnt` bytes read from buffer indices 0,1,2,… to the flash. Opcode 0xA stores `byte_cnt` read bytes at buffer indices 0,1,2,…. A count of zero issues no strobe.
- R8: Opcode 0x9 writes reg_wdata[7:0] and then, if `two_byte` is set, reg_wdata[15:8]. Opcode 0xB reads one or two bytes into `reg_rdata`: the first byte goes to bits 7:0, the second to bits 15:8, and bits 15:8 are zero in 1-byte mode.
- R9: Opcodes 0xC, 0xD, 0xE and 0xF issue no strobe while `nand_rb_n` is low. Once it is high they act as 0x4, 0x5, 0xA and 0xB respectively.
- R10: A wait that sees `nand_rb_n` low for (wait_limit+1)*4 cycles sets `timeout`, ends the program with a `done` pulse and issues nothing further. `timeout` stays set until the next accepted start.
- R11: Each WE# or RE# pulse is low for exactly one cycle, then high for at least one. WE# and RE# are never low together. Read data is captured at the clock edge that ends the RE# low cycle.
- R12: `start` is accepted only when `busy` is low. While idle, all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| instr | input | 32 | Eight packed 4-bit opcodes |
| cmd_bytes | input | 32 | Four command bytes, byte 0 in bits 31:24 |
| blk_addr | input | 24 | Block address |
| pg_addr | input | 18 | Page index, spare select and column |
| user_addr | input | 8 | Byte for the user-address opcode |
| byte_cnt | input | 12 | Buffer transfer length |
| large_page | input | 1 | Page-layout select |
| addr_len | input | 2 | Row cycles minus one |
| two_byte | input | 1 | Register transfer width select |
| wait_limit | input | 4 | Ready-wait timeout setting |
| reg_wdata | input | 16 | Data for register writes |
| reg_rdata | output | 16 | Result of register reads |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Flash write data |
| nand_din | input | 8 | Flash read data |
| nand_rb_n | input | 1 | Ready (1) / busy (0) |
| buf_addr | output | 12 | Buffer byte index |
| buf_wdata | output | 8 | Buffer write data |
| buf_we | output | 1 | Buffer write enable |
| buf_rdata | input | 8 | Buffer read data |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end pulse |
| timeout | output | 1 | Wait expired |

## Verification
Command programs in two orders (4-5-6-7 and 7-4) separate slot-order faults from command-byte selection faults. A program with a NOP in the middle and a program with eight full slots separate an early stop from an overrun. The column and row phases run in both page layouts with different row lengths, so a wrong bit field or byte order shows up as a wrong byte value. Buffer and register transfers round-trip data whose value depends on the position, which exposes index, width and byte-lane errors. A busy device released partway through a wait, a device that never becomes ready, and a second start issued during a run show whether waiting, aborting and ignoring that start each happen at the right time.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_DECODE, S_WAIT, S_XFER, S_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        K_NONE, K_CMD, K_ADDR, K_WBUF, K_RBUF, K_WREG, K_RREG
    } phase_kind_t;

    localparam int OP_W   = 4;
    localparam int PG_W   = 18;
    localparam int ROWX_W = 32;
endpackage

// File: rtl/nfs_slot_dec.sv
module nfs_slot_dec
    import nfs_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [OP_W-1:0]  op,
    input  logic             large_page,
    input  logic [1:0]       addr_len,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             two_byte,
    output phase_kind_t      kind,
    output logic [CNT_W-1:0] nbytes,
    output logic             need_wait,
    output logic [1:0]       cmd_sel,
    output logic             is_end
);
    logic [CNT_W-1:0] reg_len;
    assign reg_len = two_byte ? CNT_W'(2) : CNT_W'(1);

    always_comb begin
        kind      = K_NONE;
        nbytes    = '0;
        need_wait = 1'b0;
        cmd_sel   = 2'd0;
        is_end    = 1'b0;
        unique case (op)
            4'h0: is_end = 1'b1;
            4'h1: begin kind = K_ADDR; nbytes = large_page ? CNT_W'(2) : CNT_W'(1); end
            4'h2: begin kind = K_ADDR; nbytes = CNT_W'(addr_len) + CNT_W'(1); end
            4'h3: begin kind = K_ADDR; nbytes = CNT_W'(1); end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                kind = K_CMD; nbytes = CNT_W'(1); cmd_sel = op[1:0];
            end
            4'h8: begin kind = K_WBUF; nbytes = byte_cnt; end
            4'h9: begin kind = K_WREG; nbytes = reg_len; end
            4'hA: begin kind = K_RBUF; nbytes = byte_cnt; end
            4'hB: begin kind = K_RREG; nbytes = reg_len; end
            4'hC: begin kind = K_CMD; nbytes = CNT_W'(1); need_wait = 1'b1; cmd_sel = 2'd0; end
            4'hD: begin kind = K_CMD; nbytes = CNT_W'(1); need_wait = 1'b1; cmd_sel = 2'd1; end
            4'hE: begin kind = K_RBUF; nbytes = byte_cnt; need_wait = 1'b1; end
            4'hF: begin kind = K_RREG; nbytes = reg_len; need_wait = 1'b1; end
        endcase
    end
endmodule

// File: rtl/nfs_addr_gen.sv
module nfs_addr_gen
    import nfs_pkg::*;
#(
    parameter int BLK_W = 24
) (
    input  logic [1:0]       akind,
    input  logic [1:0]       bidx,
    input  logic             large_page,
    input  logic [PG_W-1:0]  pg_addr,
    input  logic [BLK_W-1:0] blk_addr,
    input  logic [7:0]       user_addr,
    output logic [7:0]       abyte
);
    localparam int ROW_W = BLK_W + 6;

    logic [ROW_W-1:0]  row;
    logic [ROWX_W-1:0] row_x;
    logic [7:0]        col_hi;

    always_comb begin
        if (large_page) begin
            row    = {blk_addr, pg_addr[17:12]};
            col_hi = {4'b0, pg_addr[11:8]};
        end else begin
            row    = {1'b0, blk_addr, pg_addr[14:10]};
            col_hi = {6'b0, pg_addr[9:8]};
        end
        row_x = ROWX_W'(row);
        unique case (akind)
            2'd1:    abyte = bidx[0] ? col_hi : pg_addr[7:0];
            2'd2:    abyte = row_x[8*bidx +: 8];
            default: abyte = user_addr;
        endcase
    end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nfs_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int TO_SHIFT = 2,
    parameter int SLOTS    = 8,
    parameter int BLK_W    = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SLOTS*OP_W-1:0] instr,
    input  logic [31:0]           cmd_bytes,
    input  logic [BLK_W-1:0]      blk_addr,
    input  logic [PG_W-1:0]       pg_addr,
    input  logic [7:0]            user_addr,
    input  logic [CNT_W-1:0]      byte_cnt,
    input  logic                  large_page,
    input  logic [1:0]            addr_len,
    input  logic                  two_byte,
    input  logic [3:0]            wait_limit,
    input  logic [15:0]           reg_wdata,
    output logic [15:0]           reg_rdata,
    output logic                  nand_cle,
    output logic                  nand_ale,
    output logic                  nand_we_n,
    output logic                  nand_re_n,
    output logic [7:0]            nand_dout,
    input  logic [7:0]            nand_din,
    input  logic                  nand_rb_n,
    output logic [CNT_W-1:0]      buf_addr,
    output logic [7:0]            buf_wdata,
    output logic                  buf_we,
    input  logic [7:0]            buf_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  timeout
);
    localparam int PROG_W = SLOTS * OP_W;
    localparam int SLOT_W = $clog2(SLOTS + 1);
    localparam int WC_W   = 4 + TO_SHIFT + 1;

    seq_state_t       state, state_nx;
    logic [PROG_W-1:0] prog;
    logic [SLOT_W-1:0] slot;
    logic [CNT_W-1:0]  idx;
    logic              ph;
    logic [WC_W-1:0]   wcnt;
    logic              tout;
    logic [15:0]       rdreg;

    logic [OP_W-1:0]  cur_op;
    phase_kind_t      kind;
    logic [CNT_W-1:0] nbytes;
    logic             need_wait, is_end;
    logic [1:0]       cmd_sel;
    logic [7:0]       abyte;
    logic [WC_W-1:0]  wait_lim;
    logic             prog_end, last_byte, wait_exp, advance, low_ph;

    assign cur_op    = prog[PROG_W-1 -: OP_W];
    assign wait_lim  = (WC_W'(wait_limit) + WC_W'(1)) << TO_SHIFT;
    assign prog_end  = is_end || (slot == SLOT_W'(SLOTS));
    assign last_byte = (idx == nbytes - CNT_W'(1));
    assign wait_exp  = (wcnt == wait_lim - WC_W'(1));

    nfs_slot_dec #(.CNT_W(CNT_W)) dec_i (
        .op(cur_op), .large_page(large_page), .addr_len(addr_len),
        .byte_cnt(byte_cnt), .two_byte(two_byte), .kind(kind),
        .nbytes(nbytes), .need_wait(need_wait), .cmd_sel(cmd_sel), .is_end(is_end)
    );

    nfs_addr_gen #(.BLK_W(BLK_W)) agen_i (
        .akind(cur_op[1:0]), .bidx(idx[1:0]), .large_page(large_page),
        .pg_addr(pg_addr), .blk_addr(blk_addr), .user_addr(user_addr), .abyte(abyte)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        advance  = 1'b0;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_DECODE;
            S_DECODE: begin
                if (prog_end)            state_nx = S_FINISH;
                else if (need_wait)      state_nx = S_WAIT;
                else if (nbytes == '0)   advance  = 1'b1;
                else                     state_nx = S_XFER;
            end
            S_WAIT: begin
                if (nand_rb_n) begin
                    if (nbytes == '0) begin state_nx = S_DECODE; advance = 1'b1; end
                    else state_nx = S_XFER;
                end else if (wait_exp) state_nx = S_FINISH;
            end
            S_XFER: if (ph && last_byte) begin state_nx = S_DECODE; advance = 1'b1; end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register and sequencing datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            prog  <= '0;
            slot  <= '0;
            idx   <= '0;
            ph    <= 1'b0;
            wcnt  <= '0;
            tout  <= 1'b0;
            rdreg <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                prog <= instr;
                slot <= '0;
                tout <= 1'b0;
            end
            if (advance) begin
                prog <= prog << OP_W;
                slot <= slot + SLOT_W'(1);
            end
            if (state == S_DECODE) begin
                wcnt <= '0;
                idx  <= '0;
                ph   <= 1'b0;
            end
            if (state == S_WAIT && !nand_rb_n) begin
                wcnt <= wcnt + WC_W'(1);
                if (wait_exp) tout <= 1'b1;
            end
            if (state == S_XFER) begin
                ph <= !ph;
                if (ph) idx <= last_byte ? '0 : idx + CNT_W'(1);
                if (!ph && kind == K_RREG) begin
                    if (idx[0]) rdreg[15:8] <= nand_din;
                    else        rdreg       <= {8'h00, nand_din};
                end
            end
        end
    end

    // outputs
    always_comb begin
        low_ph    = (state == S_XFER) && !ph;
        nand_cle  = (state == S_XFER) && (kind == K_CMD);
        nand_ale  = (state == S_XFER) && (kind == K_ADDR);
        nand_we_n = !(low_ph && (kind inside {K_CMD, K_ADDR, K_WBUF, K_WREG}));
        nand_re_n = !(low_ph && (kind inside {K_RBUF, K_RREG}));
        unique case (kind)
            K_CMD:   nand_dout = cmd_bytes[31 - 8*cmd_sel -: 8];
            K_ADDR:  nand_dout = abyte;
            K_WBUF:  nand_dout = buf_rdata;
            K_WREG:  nand_dout = idx[0] ? reg_wdata[15:8] : reg_wdata[7:0];
            default: nand_dout = 8'h00;
        endcase
        buf_addr  = idx;
        buf_wdata = nand_din;
        buf_we    = low_ph && (kind == K_RBUF);
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        timeout   = tout;
        reg_rdata = rdreg;
    end

    AST_WE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !nand_we_n |=> nand_we_n); // R11
    AST_RE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !nand_re_n |=> nand_re_n); // R11
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) nand_we_n || nand_re_n); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_TOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |-> done); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale)); // R12
endmodule

// File: tb/nand_seq_top_tb_top.sv
`timescale 1ns/1ps
module nand_seq_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] cmd_bytes = 32'h11223344;
    logic [23:0] blk_addr = 24'h123456;
    logic [17:0] pg_addr = '0;
    logic [7:0]  user_addr = 8'h5A;
    logic [11:0] byte_cnt = 12'd0;
    logic        large_page = 1'b0;
    logic [1:0]  addr_len = 2'd0;
    logic        two_byte = 1'b0;
    logic [3:0]  wait_limit = 4'd15;
    logic [15:0] reg_wdata = 16'hBEEF;
    logic [15:0] reg_rdata;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dout, nand_din;
    logic        nand_rb_n = 1'b1;
    logic [11:0] buf_addr;
    logic [7:0]  buf_wdata, buf_rdata;
    logic        buf_we, busy, done, timeout;

    nand_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .cmd_bytes(cmd_bytes),
        .blk_addr(blk_addr), .pg_addr(pg_addr), .user_addr(user_addr), .byte_cnt(byte_cnt),
        .large_page(large_page), .addr_len(addr_len), .two_byte(two_byte),
        .wait_limit(wait_limit), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dout(nand_dout), .nand_din(nand_din), .nand_rb_n(nand_rb_n),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .timeout(timeout)
    );

    // buffer model
    logic [7:0] bmem [0:63];
    assign buf_rdata = bmem[buf_addr[5:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bmem[i] <= 8'h3C ^ 8'(i);
        end else if (buf_we) begin
            bmem[buf_addr[5:0]] <= buf_wdata;
        end
    end

    // bus monitor: log of strobes, read source, R11 timing checks
    logic [7:0] lg_dat [0:255];
    logic       lg_cle [0:255];
    logic       lg_ale [0:255];
    logic       lg_rd  [0:255];
    int lg_n = 0, rd_ctr = 0, viol = 0;
    logic rd_pend = 1'b0, we_was_low = 1'b0, re_was_low = 1'b0;
    assign nand_din = 8'hA0 + 8'(rd_ctr);

    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n && !nand_re_n) viol++;
            if (!nand_we_n && we_was_low) viol++;
            if (!nand_re_n && re_was_low) viol++;
            we_was_low = !nand_we_n;
            re_was_low = !nand_re_n;
            if (!nand_we_n) begin
                lg_dat[lg_n[7:0]] = nand_dout; lg_cle[lg_n[7:0]] = nand_cle;
                lg_ale[lg_n[7:0]] = nand_ale;  lg_rd[lg_n[7:0]] = 1'b0;
                lg_n++;
            end
            if (!nand_re_n) begin
                lg_dat[lg_n[7:0]] = nand_din; lg_cle[lg_n[7:0]] = nand_cle;
                lg_ale[lg_n[7:0]] = nand_ale; lg_rd[lg_n[7:0]] = 1'b1;
                lg_n++;
                rd_pend = 1'b1;
            end else if (rd_pend) begin
                rd_ctr++;
                rd_pend = 1'b0;
            end
        end
    end

    int total = 0, bad = 0;
    int base = 0, rbase = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_count(input int n, input string tag);
        chk((lg_n - base) == n, tag, 32'(lg_n - base), 32'(n));
    endtask

    // flags: {cle, ale, rd}
    task automatic chk_byte(input int k, input logic [2:0] fl, input logic [7:0] v, input string tag);
        logic [7:0] p;
        logic [10:0] act;
        p = 8'(base + k);
        act = {lg_cle[p], lg_ale[p], lg_rd[p], lg_dat[p]};
        chk(act == {fl, v}, tag, 32'(act), 32'({fl, v}));
    endtask

    task automatic kick(input logic [31:0] p);
        @(negedge clk);
        base = lg_n; rbase = rd_ctr;
        instr = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 3000) chk(1'b0, "R2 done never seen", 32'(cyc), 32'd0);
    endtask

    task automatic run(input logic [31:0] p);
        kick(p);
        wait_done();
    endtask

    task automatic t_reset();
        chk({busy, done, timeout, nand_cle, nand_ale} == 5'b0, "R12 reset idle outputs",
            32'({busy, done, timeout, nand_cle, nand_ale}), 32'd0);
        chk({nand_we_n, nand_re_n} == 2'b11, "R12 reset strobes high", 32'({nand_we_n, nand_re_n}), 32'd3);
    endtask

    task automatic t_cmds();
        run(32'h4567_0000);
        chk_count(4, "R3 four command cycles");
        chk_byte(0, 3'b100, 8'h11, "R3 cmd byte0");
        chk_byte(1, 3'b100, 8'h22, "R3 cmd byte1");
        chk_byte(2, 3'b100, 8'h33, "R3 cmd byte2");
        chk_byte(3, 3'b100, 8'h44, "R3 cmd byte3");
        run(32'h7400_0000);
        chk_count(2, "R1 reversed order count");
        chk_byte(0, 3'b100, 8'h44, "R1 slot0 first");
        chk_byte(1, 3'b100, 8'h11, "R1 slot1 second");
    endtask

    task automatic t_nop();
        large_page = 1'b0; pg_addr = 18'h000AB;
        run(32'h4100_5000);
        chk_count(2, "R2 stop at first NOP");
        chk_byte(1, 3'b010, 8'hAB, "R2 column before NOP");
        @(negedge clk);
        chk({done, busy} == 2'b00, "R2 done one cycle then idle", 32'({done, busy}), 32'd0);
        run(32'h4444_4444);
        chk_count(8, "R2 eight slots max");
        run(32'h0000_0000);
        chk_count(0, "R2 empty program");
    endtask

    task automatic t_col();
        large_page = 1'b0; pg_addr = 18'h003CD;
        run(32'h1000_0000);
        chk_count(1, "R4 small column cycles");
        chk_byte(0, 3'b010, 8'hCD, "R4 small column");
        large_page = 1'b1; pg_addr = 18'h00ABC;
        run(32'h1000_0000);
        chk_count(2, "R4 large column cycles");
        chk_byte(0, 3'b010, 8'hBC, "R4 large column low");
        chk_byte(1, 3'b010, 8'h0A, "R4 large column high");
    endtask

    task automatic t_row();
        logic [31:0] row;
        large_page = 1'b0; pg_addr = 18'(5'h1A) << 10; addr_len = 2'd3;
        row = 32'({blk_addr, 5'h1A});
        run(32'h2000_0000);
        chk_count(4, "R5 small row cycles");
        for (int k = 0; k < 4; k++) chk_byte(k, 3'b010, row[8*k +: 8], "R5 small row byte");
        large_page = 1'b1; pg_addr = 18'(6'h2B) << 12; addr_len = 2'd1;
        row = 32'({blk_addr, 6'h2B});
        run(32'h2000_0000);
        chk_count(2, "R5 large row cycles");
        for (int k = 0; k < 2; k++) chk_byte(k, 3'b010, row[8*k +: 8], "R5 large row byte");
        large_page = 1'b0;
    endtask

    task automatic t_user();
        run(32'h3000_0000);
        chk_count(1, "R6 user address count");
        chk_byte(0, 3'b010, 8'h5A, "R6 user address");
    endtask

    task automatic t_buf();
        int rb;
        byte_cnt = 12'd5;
        run(32'h4800_0000);
        chk_count(6, "R7 buffer write count");
        for (int k = 0; k < 5; k++) chk_byte(k + 1, 3'b000, 8'h3C ^ 8'(k), "R7 buffer write data");
        byte_cnt = 12'd4;
        run(32'hA000_0000);
        rb = rbase;
        chk_count(4, "R7 buffer read count");
        run(32'h8000_0000);
        for (int k = 0; k < 4; k++) chk_byte(k, 3'b000, 8'hA0 + 8'(rb + k), "R7 buffer read stored");
        byte_cnt = 12'd0;
        run(32'h8400_0000);
        chk_count(1, "R7 zero count skipped");
    endtask

    task automatic t_single();
        two_byte = 1'b1;
        run(32'h9000_0000);
        chk_count(2, "R8 register write count");
        chk_byte(0, 3'b000, 8'hEF, "R8 register write low");
        chk_byte(1, 3'b000, 8'hBE, "R8 register write high");
        two_byte = 1'b0;
        run(32'hB000_0000);
        chk(reg_rdata == {8'h00, 8'hA0 + 8'(rbase)}, "R8 one byte read", 32'(reg_rdata),
            32'({8'h00, 8'hA0 + 8'(rbase)}));
        two_byte = 1'b1;
        run(32'hB000_0000);
        chk(reg_rdata == {8'hA0 + 8'(rbase + 1), 8'hA0 + 8'(rbase)}, "R8 two byte read",
            32'(reg_rdata), 32'({8'hA0 + 8'(rbase + 1), 8'hA0 + 8'(rbase)}));
    endtask

    task automatic t_wait();
        wait_limit = 4'd15; nand_rb_n = 1'b0;
        kick(32'hD000_0000);
        repeat (10) @(negedge clk);
        chk((lg_n - base) == 0 && busy, "R9 no strobe while busy device", 32'(lg_n - base), 32'd0);
        nand_rb_n = 1'b1;
        wait_done();
        chk_count(1, "R9 wait then command count");
        chk_byte(0, 3'b100, 8'h22, "R9 wait then cmd1");
        chk(!timeout, "R9 no timeout", 32'(timeout), 32'd0);
        byte_cnt = 12'd2;
        run(32'hE000_0000);
        chk_count(2, "R9 wait then buffer read");
        two_byte = 1'b0;
        run(32'hF000_0000);
        chk(reg_rdata == {8'h00, 8'hA0 + 8'(rbase)}, "R9 wait then register read",
            32'(reg_rdata), 32'({8'h00, 8'hA0 + 8'(rbase)}));
    endtask

    task automatic t_timeout();
        wait_limit = 4'd1; nand_rb_n = 1'b0;
        run(32'hC400_0000);
        chk(timeout, "R10 timeout flag", 32'(timeout), 32'd1);
        chk_count(0, "R10 aborted program issues nothing");
        chk(cyc >= 8 && cyc <= 14, "R10 timeout window", 32'(cyc), 32'd9);
        nand_rb_n = 1'b1;
        run(32'h4000_0000);
        chk(!timeout, "R10 cleared by next start", 32'(timeout), 32'd0);
        wait_limit = 4'd15;
    endtask

    task automatic t_busy_start();
        kick(32'h4440_0000);
        @(negedge clk);
        chk(busy, "R12 busy during run", 32'(busy), 32'd1);
        instr = 32'h7000_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk_count(3, "R12 start while busy ignored");
        for (int k = 0; k < 3; k++) chk_byte(k, 3'b100, 8'h11, "R12 original program kept");
    endtask

    initial begin
        #1ms;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmds();
        t_nop();
        t_col();
        t_row();
        t_user();
        t_buf();
        t_single();
        t_wait();
        t_timeout();
        t_busy_start();
        chk(viol == 0, "R11 strobe timing violations", 32'(viol), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule